// File: doc/BRIEF.md
# Maskable Interrupt Status Collector

This block gathers single-cycle event pulses from a bus-controller or remote-terminal protocol engine into a 15-bit latched status word. Each status bit is paired with an enable bit in a mask word, and one level-sensitive interrupt request goes to the host. The host reaches the block through a small synchronous register port. Through it the host writes the mask, picks the latching policy and reads the pending causes. A single status read returns every pending cause and clears them all.

Two latching policies are available. In gated mode a status bit records an event only while its mask bit is set. In capture-all mode every event is recorded whatever the mask holds, so software can poll causes it has chosen not to be interrupted by. In both modes the mask alone decides which recorded bits raise the request. Bit i of the status and mask words belongs to event input i. The event sources include end of message, end of controller message list, message error, status set, time-tag rollover, address parity error, retry, data and command stack rollover, transmitter timeout and RAM parity error. The remaining inputs are spare sources.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, reads of the mask (address 0), the mode (address 1) and the status (address 2) all return zero, gated mode is selected and `irq_o` is low.
- R2: In gated mode (mode bit 0 = 0), a pulse on `evt_i[i]` sets status bit i only if mask bit i is set.
- R3: In capture-all mode (mode bit 0 = 1), a pulse on `evt_i[i]` sets status bit i whatever mask bit i holds.
- R4: In both modes, `irq_o` is high exactly when some status bit and its mask bit are both set.
- R5: A status read (address 2, `rd_en_i` high) returns all latched bits in `rdata_o[14:0]` in that cycle, and from the next cycle those bits are clear.
- R6: An event that arrives in the same cycle as a status read is not lost: it is latched after the read, and the read itself does not show it.
- R7: A mask write takes effect from the next cycle. An event that arrives in the same cycle as the mask write is judged against the old mask.
- R8: Writes to the status address have no effect. Unused read bits return zero: bit 15 of the mask and status reads, and bits 15:1 of the mode read.
- R9: The mask and the mode bit read back as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | NUM_SRC | Event pulses, one cycle each, bit i = source i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a status read clears |
| addr_i | input | 2 | Register select: 0 mask, 1 mode, 2 status |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of `rd_en_i`, zero otherwise |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that `wr_en_i` and `rd_en_i` never address the same register in one cycle. They also assume that each event is a pulse sampled at one edge, with no clock-domain crossing. The stimulus drives every input on the falling edge, one operation per cycle. It never raises both strobes together, so the same-cycle cases that matter are each produced on purpose: a status read with an event, and a mask write with an event. The sweep visits every source bit in both modes, with the mask bit set and with it clear.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      SEL_MASK = 2'd0,
      SEL_MODE = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_stat_cell.sv
module irq_stat_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic mask_i,
   input  logic enh_i,
   input  logic clr_i,
   output logic stat_o
);
   logic stat_q;
   logic admit;

   // capture-all admits every event; gated admits only masked-in ones
   assign admit = enh_i | mask_i;

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= (stat_q & ~clr_i) | (evt_i & admit);
   end

   assign stat_o = stat_q;

   // R2
   gated_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enh_i && !mask_i && (clr_i || !stat_q)) |=> !stat_o);
   // R3
   capture_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enh_i && evt_i) |=> stat_o);
   // R6
   clr_keep_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && evt_i && mask_i) |=> stat_o);
   // R5
   clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> !stat_o);
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 15,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NUM_SRC-1:0] stat_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic              enh_o,
   output logic              clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic [NUM_SRC-1:0] mask_q;
   logic               enh_q;
   logic               hit_mask, hit_mode, hit_stat;

   assign hit_mask = (addr_i == SEL_MASK);
   assign hit_mode = (addr_i == SEL_MODE);
   assign hit_stat = (addr_i == SEL_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         enh_q  <= 1'b0;
      end else if (wr_en_i) begin
         if (hit_mask) mask_q <= wdata_i[NUM_SRC-1:0];
         if (hit_mode) enh_q  <= wdata_i[0];
      end
   end

   assign mask_o = mask_q;
   assign enh_o  = enh_q;
   assign clr_o  = rd_en_i & hit_stat;

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         if (hit_mask) rdata_o[NUM_SRC-1:0] = mask_q;
         if (hit_mode) rdata_o[0]           = enh_q;
         if (hit_stat) rdata_o[NUM_SRC-1:0] = stat_i;
      end
   end

   // R9
   mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && hit_mode) |=> (enh_o == $past(wdata_i[0])));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 15,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_o
);
   localparam int SPARE_W = DATA_W - NUM_SRC;

   generate
      if (NUM_SRC < 1 || SPARE_W < 0) begin : g_bad_width
         $error("NUM_SRC must lie between 1 and DATA_W");
      end
   endgenerate

   logic [NUM_SRC-1:0] mask_w, stat_w;
   logic               enh_w, clr_w;

   irq_host_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .stat_i  (stat_w),
      .mask_o  (mask_w),
      .enh_o   (enh_w),
      .clr_o   (clr_w),
      .rdata_o (rdata_o)
   );

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
         irq_stat_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_i[i]),
            .mask_i (mask_w[i]),
            .enh_i  (enh_w),
            .clr_i  (clr_w),
            .stat_o (stat_w[i])
         );
      end
   endgenerate

   assign irq_o = |(stat_w & mask_w);

   // R7
   mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == SEL_MASK && wdata_i[NUM_SRC-1:0] == '0) |=> !irq_o);
   // R5
   read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && evt_i == '0) |=> !irq_o);
   // R8
   stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !rd_en_i && addr_i == SEL_STAT && evt_i == '0) |=> $stable(stat_w));
   // R4
   irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $stable(mask_w)) |-> (mask_w != '0));
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
   localparam int NS = 15;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] evt = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   logic [NS-1:0] m_mask = '0;
   logic [NS-1:0] m_stat = '0;
   logic          m_enh  = 1'b0;

   always #2 clk = ~clk;

   irq_status_ctrl #(.NUM_SRC(NS), .DATA_W(DW)) i_irq_status_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one operation per cycle, driven at the falling edge
   task automatic cyc(input string tag, input logic [NS-1:0] e, input logic wr,
                      input logic rd, input logic [1:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] exp_rd;
      logic [NS-1:0] nxt;
      evt = e; wr_en = wr; rd_en = rd; addr = a; wdata = d;
      #1;
      if (rd) begin
         exp_rd = '0;
         if (a == 2'd0) exp_rd[NS-1:0] = m_mask;
         if (a == 2'd1) exp_rd[0]      = m_enh;
         if (a == 2'd2) exp_rd[NS-1:0] = m_stat;
         check(tag, rdata, exp_rd);
      end
      nxt = ((rd && a == 2'd2) ? '0 : m_stat) | (e & (m_enh ? {NS{1'b1}} : m_mask));
      if (wr && a == 2'd0) m_mask = d[NS-1:0];
      if (wr && a == 2'd1) m_enh  = d[0];
      m_stat = nxt;
      @(posedge clk);
      @(negedge clk);
      evt = '0; wr_en = 1'b0; rd_en = 1'b0;
      // R4: request follows status AND mask
      check("R4 irq", {15'd0, irq}, {15'd0, |(m_stat & m_mask)});
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 irq", {15'd0, irq}, 16'd0);
      cyc("R1 mask", '0, 1'b0, 1'b1, 2'd0, '0);
      cyc("R1 mode", '0, 1'b0, 1'b1, 2'd1, '0);
      cyc("R1 stat", '0, 1'b0, 1'b1, 2'd2, '0);

      // R2 / R3 / R5 sweep over every source, both modes, mask in and out
      for (int md = 0; md < 2; md++) begin
         cyc("R9 mode wr", '0, 1'b1, 1'b0, 2'd1, DW'(md));
         cyc("R9 mode rd", '0, 1'b0, 1'b1, 2'd1, '0);
         for (int b = 0; b < NS; b++) begin
            for (int mm = 0; mm < 2; mm++) begin
               logic [NS-1:0] one;
               one = NS'(1) << b;
               cyc("R9 mask wr", '0, 1'b1, 1'b0, 2'd0, {1'b0, (mm != 0) ? one : ~one});
               cyc("R9 mask rd", '0, 1'b0, 1'b1, 2'd0, '0);
               cyc("R2R3 evt", one, 1'b0, 1'b0, 2'd3, '0);
               cyc(md != 0 ? "R3 stat rd" : "R2 stat rd", '0, 1'b0, 1'b1, 2'd2, '0);
               cyc("R5 after clr", '0, 1'b0, 1'b1, 2'd2, '0);
            end
         end
      end

      // R4 / R5 multi-bit patterns computed arithmetically
      for (int k = 0; k < 48; k++) begin
         int mv, ev, ev2;
         mv  = (k * 32'h1D35) ^ (k << 3);
         ev  = (k * 32'h2A7B) >> 1;
         ev2 = (k * 32'h0517) ^ 32'h5A5A;
         cyc("R9 mode wr", '0, 1'b1, 1'b0, 2'd1, DW'(k & 1));
         cyc("R9 mask wr", '0, 1'b1, 1'b0, 2'd0, DW'(mv));
         cyc("R4 evt", NS'(ev), 1'b0, 1'b0, 2'd3, '0);
         cyc("R4 evt2", NS'(ev2), 1'b0, 1'b0, 2'd3, '0);
         cyc("R5 stat rd", '0, 1'b0, 1'b1, 2'd2, '0);
      end

      // R6 event in the same cycle as a status read
      cyc("R6 mode", '0, 1'b1, 1'b0, 2'd1, 16'h0001);
      cyc("R6 evt", 15'h00F0, 1'b0, 1'b0, 2'd3, '0);
      cyc("R6 rd+evt", 15'h0005, 1'b0, 1'b1, 2'd2, '0);
      check("R6 model", {1'b0, m_stat}, 16'h0005);
      cyc("R6 rd again", '0, 1'b0, 1'b1, 2'd2, '0);

      // R7 mask write and event in the same cycle
      cyc("R7 mode", '0, 1'b1, 1'b0, 2'd1, 16'h0000);
      cyc("R7 mask0", '0, 1'b1, 1'b0, 2'd0, 16'h0000);
      cyc("R7 wr+evt", 15'h0001, 1'b1, 1'b0, 2'd0, 16'h0001);
      cyc("R7 stat rd", '0, 1'b0, 1'b1, 2'd2, '0);
      cyc("R7 evt", 15'h0001, 1'b0, 1'b0, 2'd3, '0);
      cyc("R7 stat rd2", '0, 1'b0, 1'b1, 2'd2, '0);

      // R8 status is read-only, unused bits read zero
      cyc("R8 mask all", '0, 1'b1, 1'b0, 2'd0, 16'hFFFF);
      cyc("R8 mask rd", '0, 1'b0, 1'b1, 2'd0, '0);
      cyc("R8 evt", 15'h0300, 1'b0, 1'b0, 2'd3, '0);
      cyc("R8 stat wr", '0, 1'b1, 1'b0, 2'd2, 16'hFFFF);
      cyc("R8 stat rd", '0, 1'b0, 1'b1, 2'd2, '0);
      cyc("R8 stat wr0", 15'h0002, 1'b0, 1'b0, 2'd3, '0);
      cyc("R8 stat wr0b", '0, 1'b1, 1'b0, 2'd2, 16'h0000);
      cyc("R8 stat rd2", '0, 1'b0, 1'b1, 2'd2, '0);
      cyc("R8 mode wr", '0, 1'b1, 1'b0, 2'd1, 16'hFFFF);
      cyc("R8 mode rd", '0, 1'b0, 1'b1, 2'd1, '0);
      check("R8 mode bits", {15'd0, m_enh}, 16'h0001);
      cyc("R8 none rd", '0, 1'b0, 1'b1, 2'd3, '0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule